// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the delivery state of a bank of interrupt sources on the way to a single interrupt presenter. Each source is fixed at build time as either a message-type source, where one pulse on its input is one event, or a level-type source, where the input is a level that stays high until the device is serviced. Per source the block keeps a target server, a priority, a saved priority and four status flags: asserted, sent, rejected and masked-pending. Priority 0xFF means masked.

Sources that become eligible are queued as per-source request bits. A presentation FSM (`P_IDLE`, `P_GAP`) turns them into presentations. Each presentation is a one-cycle valid pulse that carries the global source number (base offset plus local index), the server and the priority. The presenter answers through three inputs. It can reject a source, signal end-of-interrupt for a source, or ask for a resend. On a resend, a scan FSM (`S_IDLE`, `S_WALK`) visits every source in index order and re-evaluates it. The walk stops while any presentation is queued or in flight. Transitions: `P_IDLE`→`P_GAP` when a request is granted, and `P_GAP`→`P_IDLE` on the next cycle. `S_IDLE`→`S_WALK` on a resend command, and `S_WALK`→`S_IDLE` once the last index has been visited.

Top module: `irq_src_ctrl`

## Requirements
- R1: A presentation carries global number BASE + local index (default BASE 0x1000) and the server and priority from the most recent configuration write. A configuration write stores server, priority and saved priority for the source at `cfg_idx`.
- R2: A message-type event on a source whose priority is 0xFF sets masked-pending and presents nothing. With any other priority, `pres_valid` rises two rising edges after the event is sampled.
- R3: A configuration write with a priority other than 0xFF to a message-type source that has masked-pending set clears that flag and presents the source once. A write with 0xFF presents nothing.
- R4: A level-type source is re-checked whenever its input changes. It is presented, and sent is set, when its priority is not 0xFF, its input is high and sent is clear. While it stays high it is not presented again.
- R5: A reject of a message-type source sets rejected. The next resend clears the flag and presents the source again. A further resend presents nothing.
- R6: A reject of a level-type source clears sent. A resend then presents the source again if its input is still high.
- R7: An end-of-interrupt clears sent on a level-type source, so the next resend presents it again. On a message-type source it has no effect, so a rejected flag survives it.
- R8: Reset clears every status flag and request and sets priority and saved priority to 0xFF. `pres_valid` is low during reset. Each source's message or level type is unchanged by reset.
- R9: Each presentation is followed by at least one cycle without one. A reject that arrives in the cycle after a presentation takes effect before the next presentation.
- R10: When several sources request at once, they are presented one at a time, lowest local index first.
- R11: A resend visits the sources in ascending index order, one per cycle, and pauses while a presentation is queued or in flight. Rejected message sources are therefore presented in index order.
- R12: A configuration write of priority 0xFF to a source with a request still queued cancels the request. A message-type source then gets masked-pending, so no presentation ever carries priority 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_in | input | N | Per-source input: event pulse (message type) or level (level type) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index written |
| cfg_srv | input | SRV_W | Target server to store |
| cfg_prio | input | 8 | Priority to store (0xFF masks) |
| cfg_saved | input | 8 | Saved priority to store |
| rej_valid | input | 1 | Reject notification from the presenter |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt notification |
| eoi_num | input | NUM_W | Global number being completed |
| resend | input | 1 | Start a resend walk over all sources |
| pres_valid | output | 1 | Presentation pulse |
| pres_num | output | NUM_W | Global number presented |
| pres_srv | output | SRV_W | Server of the presented source |
| pres_prio | output | 8 | Priority of the presented source |

## Verification
An event or configuration write sampled at one rising edge sets a request bit. The request is granted at the next edge and is visible on `pres_valid` after it, two edges in all. A resend needs at least three edges, plus two more for each presentation the walk makes before reaching a given source. The bench drives inputs on falling edges. It counts presentations at rising edges, when the registered outputs are stable. It compares counts and the logged source numbers only after a settling window longer than these latencies. For the same-cycle cases (reject or masking just after a presentation), it waits for `pres_valid` and drives the reply in that same cycle.

// File: rtl/irqsrc_pkg.sv
`timescale 1ns/1ps
package irqsrc_pkg;
    localparam logic [7:0] PRIO_MASKED = 8'hFF;

    typedef struct packed {
        logic asserted;
        logic sent;
        logic rejected;
        logic mpend;
    } src_stat_t;

    typedef enum logic {P_IDLE, P_GAP}  pres_state_e;
    typedef enum logic {S_IDLE, S_WALK} scan_state_e;
endpackage

// File: rtl/irqsrc_slot.sv
`timescale 1ns/1ps
module irqsrc_slot
    import irqsrc_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0,
    parameter int SRV_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic             cfg_hit,
    input  logic [SRV_W-1:0] cfg_srv,
    input  logic [7:0]       cfg_prio,
    input  logic [7:0]       cfg_saved,
    input  logic             rej_hit,
    input  logic             eoi_hit,
    input  logic             scan_hit,
    input  logic             grant,
    output logic             req,
    output logic [SRV_W-1:0] srv,
    output logic [7:0]       prio,
    output logic [7:0]       saved
);
    src_stat_t        st_q, st_n;
    logic [SRV_W-1:0] srv_n;
    logic [7:0]       prio_n, saved_n;
    logic             req_n, chk;

    always_comb begin
        st_n    = st_q;
        srv_n   = srv;
        prio_n  = prio;
        saved_n = saved;
        req_n   = req & ~grant;
        chk     = 1'b0;
        // presenter refused the source
        if (rej_hit) begin
            if (IS_LEVEL) st_n.sent = 1'b0;
            else          st_n.rejected = 1'b1;
        end
        if (eoi_hit && IS_LEVEL) st_n.sent = 1'b0;
        // configuration update
        if (cfg_hit) begin
            srv_n   = cfg_srv;
            prio_n  = cfg_prio;
            saved_n = cfg_saved;
            if (IS_LEVEL) begin
                chk = 1'b1;
            end else if (st_n.mpend && cfg_prio != PRIO_MASKED) begin
                st_n.mpend = 1'b0;
                req_n      = 1'b1;
            end
        end
        // input side
        if (IS_LEVEL) begin
            if (evt_in != st_n.asserted) begin
                st_n.asserted = evt_in;
                chk           = 1'b1;
            end
        end else if (evt_in) begin
            if (prio_n == PRIO_MASKED) st_n.mpend = 1'b1;
            else                       req_n = 1'b1;
        end
        // resend walk visiting this source
        if (scan_hit) begin
            if (IS_LEVEL) begin
                chk = 1'b1;
            end else if (st_n.rejected) begin
                st_n.rejected = 1'b0;
                if (prio_n != PRIO_MASKED) req_n = 1'b1;
            end
        end
        // level rule
        if (IS_LEVEL && chk && prio_n != PRIO_MASKED && st_n.asserted && !st_n.sent) begin
            st_n.sent = 1'b1;
            req_n     = 1'b1;
        end
        // a masked source never keeps a queued request
        if (req_n && prio_n == PRIO_MASKED) begin
            req_n = 1'b0;
            if (IS_LEVEL) st_n.sent  = 1'b0;
            else          st_n.mpend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            srv   <= '0;
            prio  <= PRIO_MASKED;
            saved <= PRIO_MASKED;
            req   <= 1'b0;
        end else begin
            st_q  <= st_n;
            srv   <= srv_n;
            prio  <= prio_n;
            saved <= saved_n;
            req   <= req_n;
        end
    end
endmodule

// File: rtl/irqsrc_arb.sv
`timescale 1ns/1ps
module irqsrc_arb
    import irqsrc_pkg::*;
#(
    parameter int          N     = 8,
    parameter int          SRV_W = 4,
    parameter int          NUM_W = 16,
    parameter int unsigned BASE  = 32'h1000,
    localparam int         IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              req,
    input  logic [N-1:0][SRV_W-1:0]   srv_all,
    input  logic [N-1:0][7:0]         prio_all,
    output logic [N-1:0]              grant,
    output logic                      busy,
    output logic                      pres_valid,
    output logic [NUM_W-1:0]          pres_num,
    output logic [SRV_W-1:0]          pres_srv,
    output logic [7:0]                pres_prio
);
    pres_state_e      state_q, state_n;
    logic             any;
    logic [IDX_W-1:0] sel;

    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                any = 1'b1;
                sel = IDX_W'(k);
            end
        end
    end

    always_comb begin
        grant   = '0;
        state_n = state_q;
        unique case (state_q)
            P_IDLE: if (any) begin
                grant[sel] = 1'b1;
                state_n    = P_GAP;
            end
            P_GAP: state_n = P_IDLE;
        endcase
    end

    assign busy = any || (state_q != P_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_valid <= 1'b0;
            pres_num   <= '0;
            pres_srv   <= '0;
            pres_prio  <= '0;
        end else begin
            pres_valid <= |grant;
            if (|grant) begin
                pres_num  <= NUM_W'(BASE) + NUM_W'(sel);
                pres_srv  <= srv_all[sel];
                pres_prio <= prio_all[sel];
            end
        end
    end
endmodule

// File: rtl/irqsrc_scan.sv
`timescale 1ns/1ps
module irqsrc_scan
    import irqsrc_pkg::*;
#(
    parameter int  N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hold,
    output logic             scan_valid,
    output logic [IDX_W-1:0] scan_idx
);
    scan_state_e state_q, state_n;
    logic        last;

    assign last       = (scan_idx == IDX_W'(N - 1));
    assign scan_valid = (state_q == S_WALK) && !hold;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_n = S_WALK;
            S_WALK: if (scan_valid && last) state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          scan_idx <= '0;
        else if (state_q == S_IDLE)          scan_idx <= '0;
        else if (scan_valid && !last)        scan_idx <= scan_idx + 1'b1;
    end
endmodule

// File: rtl/irq_src_ctrl.sv
`timescale 1ns/1ps
module irq_src_ctrl
    import irqsrc_pkg::*;
#(
    parameter int          N          = 8,
    parameter int          SRV_W      = 4,
    parameter int          NUM_W      = 16,
    parameter int unsigned BASE       = 32'h1000,
    parameter int unsigned LEVEL_MASK = 32'h0000_00F0,
    localparam int         IDX_W      = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     src_in,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [SRV_W-1:0] cfg_srv,
    input  logic [7:0]       cfg_prio,
    input  logic [7:0]       cfg_saved,
    input  logic             rej_valid,
    input  logic [NUM_W-1:0] rej_num,
    input  logic             eoi_valid,
    input  logic [NUM_W-1:0] eoi_num,
    input  logic             resend,
    output logic             pres_valid,
    output logic [NUM_W-1:0] pres_num,
    output logic [SRV_W-1:0] pres_srv,
    output logic [7:0]       pres_prio
);
    logic [N-1:0]            req;
    logic [N-1:0]            grant;
    logic [N-1:0][SRV_W-1:0] srv_all;
    logic [N-1:0][7:0]       prio_all;
    logic [N-1:0][7:0]       saved_all;
    logic                    scan_valid;
    logic [IDX_W-1:0]        scan_idx;
    logic                    arb_busy;

    for (genvar i = 0; i < N; i++) begin : g_src
        localparam logic [NUM_W-1:0] MY_NUM = NUM_W'(BASE + i);
        irqsrc_slot #(
            .IS_LEVEL (LEVEL_MASK[i]),
            .SRV_W    (SRV_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_in    (src_in[i]),
            .cfg_hit   (cfg_we && cfg_idx == IDX_W'(i)),
            .cfg_srv   (cfg_srv),
            .cfg_prio  (cfg_prio),
            .cfg_saved (cfg_saved),
            .rej_hit   (rej_valid && rej_num == MY_NUM),
            .eoi_hit   (eoi_valid && eoi_num == MY_NUM),
            .scan_hit  (scan_valid && scan_idx == IDX_W'(i)),
            .grant     (grant[i]),
            .req       (req[i]),
            .srv       (srv_all[i]),
            .prio      (prio_all[i]),
            .saved     (saved_all[i])
        );
    end

    irqsrc_arb #(
        .N     (N),
        .SRV_W (SRV_W),
        .NUM_W (NUM_W),
        .BASE  (BASE)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .srv_all    (srv_all),
        .prio_all   (prio_all),
        .grant      (grant),
        .busy       (arb_busy),
        .pres_valid (pres_valid),
        .pres_num   (pres_num),
        .pres_srv   (pres_srv),
        .pres_prio  (pres_prio)
    );

    irqsrc_scan #(.N(N)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (resend),
        .hold       (arb_busy),
        .scan_valid (scan_valid),
        .scan_idx   (scan_idx)
    );
endmodule

// File: rtl/irqsrc_chk.sv
`timescale 1ns/1ps
module irqsrc_chk #(
    parameter int          N     = 8,
    parameter int          NUM_W = 16,
    parameter int unsigned BASE  = 32'h1000,
    parameter int          IDX_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pres_valid,
    input logic [NUM_W-1:0]     pres_num,
    input logic [7:0]           pres_prio,
    input logic [N-1:0]         grant,
    input logic                 scan_valid,
    input logic                 cfg_we,
    input logic [IDX_W-1:0]     cfg_idx,
    input logic [7:0]           cfg_saved,
    input logic [N-1:0][7:0]    saved_all
);
    localparam logic [NUM_W-1:0] LO = NUM_W'(BASE);
    localparam logic [NUM_W-1:0] HI = NUM_W'(BASE + N);

    a_r9_gap_after_pres: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid |=> !pres_valid);

    a_r1_num_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid |-> (pres_num >= LO && pres_num < HI));

    a_r1_cfg_saved_stored: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> saved_all[$past(cfg_idx)] == $past(cfg_saved));

    a_r12_never_masked: assert property (@(posedge clk) disable iff (!rst_n)
        pres_valid |-> pres_prio != 8'hFF);

    a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r11_walk_paused: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid |-> !pres_valid);
endmodule

bind irq_src_ctrl irqsrc_chk #(
    .N     (N),
    .NUM_W (NUM_W),
    .BASE  (BASE),
    .IDX_W (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pres_valid (pres_valid),
    .pres_num   (pres_num),
    .pres_prio  (pres_prio),
    .grant      (grant),
    .scan_valid (scan_valid),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_saved  (cfg_saved),
    .saved_all  (saved_all)
);

// File: tb/sim_irq_src_ctrl.sv
`timescale 1ns/1ps
module sim_irq_src_ctrl;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_in = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [3:0]  cfg_srv = '0;
    logic [7:0]  cfg_prio = '0;
    logic [7:0]  cfg_saved = '0;
    logic        rej_valid = 1'b0;
    logic [15:0] rej_num = '0;
    logic        eoi_valid = 1'b0;
    logic [15:0] eoi_num = '0;
    logic        resend = 1'b0;
    logic        pres_valid;
    logic [15:0] pres_num;
    logic [3:0]  pres_srv;
    logic [7:0]  pres_prio;

    irq_src_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_srv(cfg_srv),
        .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
        .rej_valid(rej_valid), .rej_num(rej_num),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend(resend),
        .pres_valid(pres_valid), .pres_num(pres_num),
        .pres_srv(pres_srv), .pres_prio(pres_prio)
    );

    always #2 clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    int          pres_cnt = 0;
    int          b2b = 0;
    int          cyc = 0;
    logic        prev_v = 1'b0;
    logic [15:0] log_num [64];
    logic [15:0] last_num = '0;
    logic [7:0]  last_prio = '0;
    logic [3:0]  last_srv = '0;

    // presentation monitor, rising edge
    always @(posedge clk) begin
        cyc++;
        if (pres_valid) begin
            if (pres_cnt < 64) log_num[pres_cnt] = pres_num;
            pres_cnt++;
            last_num  = pres_num;
            last_prio = pres_prio;
            last_srv  = pres_srv;
            if (prev_v) b2b++;
        end
        prev_v = pres_valid;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic cfg(input logic [2:0] idx, input logic [3:0] srv, input logic [7:0] prio);
        cfg_we = 1'b1; cfg_idx = idx; cfg_srv = srv; cfg_prio = prio; cfg_saved = prio ^ 8'h5A;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic fire(input logic [7:0] m);
        src_in = src_in | m;
        tick(1);
        src_in = src_in & ~m;
    endtask

    task automatic rej(input logic [15:0] num);
        rej_valid = 1'b1; rej_num = num;
        tick(1);
        rej_valid = 1'b0;
    endtask

    task automatic eoi(input logic [15:0] num);
        eoi_valid = 1'b1; eoi_num = num;
        tick(1);
        eoi_valid = 1'b0;
    endtask

    task automatic do_resend();
        resend = 1'b1;
        tick(1);
        resend = 1'b0;
        tick(40);
    endtask

    task automatic wait_pres();
        for (int k = 0; k < 20; k++) begin
            if (pres_valid) break;
            tick(1);
        end
    endtask

    typedef struct packed {
        logic [2:0] idx;
        logic [3:0] srv;
        logic [7:0] prio;
        logic       expect_p;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{3'd1, 4'd1, 8'h10, 1'b1},
        '{3'd2, 4'd3, 8'h20, 1'b1},
        '{3'd3, 4'hF, 8'h05, 1'b1},
        '{3'd1, 4'd1, 8'hFF, 1'b0}
    };

    initial begin
        int base;
        tick(3);
        check("R8 pres_valid low in reset", pres_valid, 0);
        rst_n = 1'b1;
        tick(2);
        check("R8 pres_valid low after reset", pres_valid, 0);

        // R8/R2: message event on reset (masked) priority -> masked-pending only
        base = pres_cnt;
        fire(8'h01);
        tick(4);
        check("R2 masked event presents nothing", pres_cnt - base, 0);
        // R8: level source with reset priority stays silent
        src_in[4] = 1'b1;
        tick(4);
        check("R8 level with reset priority silent", pres_cnt - base, 0);
        src_in[4] = 1'b0;
        tick(2);

        // R3: config releases masked-pending
        base = pres_cnt;
        cfg(3'd0, 4'd2, 8'h03);
        tick(4);
        check("R3 cfg releases masked-pending count", pres_cnt - base, 1);
        check("R1 number of source 0", last_num, 16'h1000);
        check("R1 server of source 0", last_srv, 4'd2);
        check("R1 priority of source 0", last_prio, 8'h03);

        // table of message events
        foreach (VECS[v]) begin
            base = pres_cnt;
            cfg(VECS[v].idx, VECS[v].srv, VECS[v].prio);
            fire(8'h01 << VECS[v].idx);
            tick(4);
            check("R2 vector presentation count", pres_cnt - base, VECS[v].expect_p ? 1 : 0);
            if (VECS[v].expect_p) begin
                check("R1 vector number", last_num, 16'h1000 + VECS[v].idx);
                check("R1 vector server", last_srv, VECS[v].srv);
                check("R2 vector priority", last_prio, VECS[v].prio);
            end
        end
        // source 1 now masked-pending
        base = pres_cnt;
        cfg(3'd1, 4'd2, 8'h30);
        tick(4);
        check("R3 second release count", pres_cnt - base, 1);
        check("R3 second release priority", last_prio, 8'h30);

        // R4 level source 4 (local index 4 is level type)
        base = pres_cnt;
        cfg(3'd4, 4'd1, 8'h08);
        tick(3);
        check("R4 level low no presentation", pres_cnt - base, 0);
        src_in[4] = 1'b1;
        tick(4);
        check("R4 level rise presents", pres_cnt - base, 1);
        check("R4 level number", last_num, 16'h1004);
        tick(8);
        check("R4 held level not re-presented", pres_cnt - base, 1);
        base = pres_cnt;
        do_resend();
        check("R4 resend with sent set silent", pres_cnt - base, 0);

        // R7 EOI on level source
        base = pres_cnt;
        eoi(16'h1004);
        tick(4);
        check("R7 eoi alone presents nothing", pres_cnt - base, 0);
        do_resend();
        check("R7 resend after eoi presents", pres_cnt - base, 1);
        // R6 reject on level source
        base = pres_cnt;
        rej(16'h1004);
        do_resend();
        check("R6 level reject then resend", pres_cnt - base, 1);
        check("R6 level number", last_num, 16'h1004);
        src_in[4] = 1'b0;
        tick(4);

        // R5 message reject / resend
        base = pres_cnt;
        rej(16'h1002);
        do_resend();
        check("R5 rejected message re-presented", pres_cnt - base, 1);
        check("R5 re-presented number", last_num, 16'h1002);
        base = pres_cnt;
        do_resend();
        check("R5 second resend silent", pres_cnt - base, 0);

        // R7 EOI does not clear rejected on message source
        base = pres_cnt;
        rej(16'h1003);
        eoi(16'h1003);
        tick(3);
        check("R7 eoi on message presents nothing", pres_cnt - base, 0);
        do_resend();
        check("R7 rejected survives eoi", pres_cnt - base, 1);
        check("R7 number after eoi", last_num, 16'h1003);

        // R9/R10 simultaneous events, reject right after first presentation
        base = pres_cnt;
        b2b = 0;
        fire(8'h0C);
        wait_pres();
        check("R10 lowest index first", pres_num, 16'h1002);
        rej(16'h1002);
        tick(6);
        check("R10 both presented", pres_cnt - base, 2);
        check("R10 second is index 3", log_num[(base + 1) % 64], 16'h1003);
        check("R9 no back-to-back presentations", b2b, 0);
        do_resend();
        check("R9 reject in gap cycle applied", pres_cnt - base, 3);
        check("R9 rejected source re-presented", last_num, 16'h1002);

        // R11 walk order
        base = pres_cnt;
        rej(16'h1003);
        rej(16'h1001);
        rej(16'h1000);
        tick(2);
        resend = 1'b1;
        tick(1);
        resend = 1'b0;
        tick(60);
        check("R11 walk count", pres_cnt - base, 3);
        check("R11 first in walk", log_num[base % 64], 16'h1000);
        check("R11 second in walk", log_num[(base + 1) % 64], 16'h1001);
        check("R11 third in walk", log_num[(base + 2) % 64], 16'h1003);

        // R12 masking cancels queued request
        base = pres_cnt;
        fire(8'h03);
        wait_pres();
        check("R12 first presented source 0", pres_num, 16'h1000);
        cfg(3'd1, 4'd2, 8'hFF);
        tick(6);
        check("R12 queued request cancelled", pres_cnt - base, 1);
        cfg(3'd1, 4'd7, 8'h31);
        tick(4);
        check("R12 released after unmask", pres_cnt - base, 2);
        check("R12 released priority", last_prio, 8'h31);

        // R8 second reset: configuration gone, type kept
        rst_n = 1'b0;
        tick(2);
        check("R8 pres_valid low in second reset", pres_valid, 0);
        rst_n = 1'b1;
        tick(2);
        base = pres_cnt;
        fire(8'h04);
        tick(4);
        check("R8 priority back to masked", pres_cnt - base, 0);
        cfg(3'd2, 4'd1, 8'h04);
        tick(4);
        check("R8 masked-pending after reset released", pres_cnt - base, 1);
        check("R8 released priority", last_prio, 8'h04);
        base = pres_cnt;
        cfg(3'd5, 4'd1, 8'h06);
        src_in[5] = 1'b1;
        tick(12);
        check("R8 level type kept over reset", pres_cnt - base, 1);
        src_in[5] = 1'b0;
        tick(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule